// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit of parameterised width, 32 bits by default. A 4-bit operation code selects one of six functions on two operands: bitwise AND, OR and NOR, two's-complement addition and subtraction, and a signed less-than compare. Every operation returns a full-width result together with four condition flags: zero, sign, signed overflow and carry-out.

It sits in an execute stage between register-read and write-back logic, and in any other place where a datapath needs one arithmetic or logical result per cycle. Subtraction reuses the adder. The second operand is inverted and a carry-in of one is forced, so add, subtract and compare share one carry chain. The outputs follow the inputs within the same cycle. Any pipeline register belongs to the logic that surrounds the block.

Top module: `alu_status_core`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of the operands. Code 4'b0001 gives the bitwise OR. Code 4'b1100 gives the bitwise NOR.
- R2: Code 4'b0010 gives the sum of the operands modulo 2^WIDTH. Carry is set to the carry out of the most significant bit.
- R3: Code 4'b0110 gives A minus B modulo 2^WIDTH. Carry is 1 exactly when A is greater than or equal to B as unsigned values, meaning no borrow occurred.
- R4: Overflow is 1 for add and subtract exactly when the true signed result does not fit in WIDTH bits.
- R5: Code 4'b0111 returns 1 in bit 0 when A is less than B as signed values and 0 otherwise, with all higher bits 0. The compare is correct even when A minus B overflows. Carry and overflow are 0 for this code.
- R6: Zero is 1 exactly when all result bits are 0.
- R7: Sign equals the most significant result bit.
- R8: For the AND, OR and NOR codes, carry and overflow are both 0.
- R9: Every other code yields an all-zero result, carry 0 and overflow 0, so zero reads 1 and sign reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Most significant result bit |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of add or subtract |

## Verification
The block holds no state, so the result and all four flags are due in the same cycle that the operands and code are applied. The bench drives a new vector just after each rising clock edge. At the next falling edge it compares all outputs against a reference model written with wide signed integers, so the sampled values have settled and no cycle of delay is assumed. The directed vectors cover the carry, borrow and overflow corners, including compares across overflow and every unused code. A seeded pseudo-random sweep then adds bulk coverage.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff  = b_i ^ {WIDTH{sub_i}};
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sum_o  = full[WIDTH-1:0];
    cout_o = full[WIDTH];
    ovf_o  = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (full[WIDTH-1] != a_i[WIDTH-1]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    nor_o = ~(a_i | b_i);
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             sign_o
);
  always_comb begin
    zero_o = (res_i == '0);
    sign_o = res_i[WIDTH-1];
  end
endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
  import alu_status_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             ovf_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  logic             sub_mode;
  logic             arith_sel;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic             ovf_w;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic [WIDTH-1:0] nor_w;
  logic             less_w;
  logic [WIDTH-1:0] res_w;

  assign sub_mode  = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign arith_sel = (op_i == OP_ADD) || (op_i == OP_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_mode),
    .sum_o (sum_w),
    .cout_o(cout_w),
    .ovf_o (ovf_w)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i  (a_i),
    .b_i  (b_i),
    .and_o(and_w),
    .or_o (or_w),
    .nor_o(nor_w)
  );

  // signed less-than survives overflow: true sign = sum sign xor overflow
  assign less_w = sum_w[MSB] ^ ovf_w;

  always_comb begin
    case (op_i)
      OP_AND:  res_w = and_w;
      OP_OR:   res_w = or_w;
      OP_NOR:  res_w = nor_w;
      OP_ADD:  res_w = sum_w;
      OP_SUB:  res_w = sum_w;
      OP_SLT:  res_w = {{(WIDTH-1){1'b0}}, less_w};
      default: res_w = '0;
    endcase
  end

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res_i (res_w),
    .zero_o(zero_o),
    .sign_o(sign_o)
  );

  assign result_o = res_w;
  assign carry_o  = arith_sel & cout_w;
  assign ovf_o    = arith_sel & ovf_w;

  always_comb begin
    if (op_i == OP_SUB)
      AST_SUB_NO_BORROW: assert (carry_o == (a_i >= b_i)); // R3
    if (op_i == OP_ADD && ovf_o)
      AST_ADD_OVF_SIGNS: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]); // R4
    if (op_i == OP_SLT)
      AST_SLT_UPPER_CLEAR: assert (result_o[MSB:1] == '0 && !carry_o && !ovf_o); // R5
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_NOR)
      AST_LOGIC_NO_CARRY: assert (!carry_o && !ovf_o); // R8
    if (!(arith_sel || op_i == OP_SLT || op_i == OP_AND || op_i == OP_OR || op_i == OP_NOR))
      AST_UNDEF_ZERO: assert (result_o == '0 && zero_o && !sign_o && !carry_o && !ovf_o); // R9
    if (zero_o)
      AST_ZERO_NOT_NEG: assert (!sign_o); // R7
  end
endmodule

// File: tb/alu_status_core_tb.sv
module alu_status_core_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res;
  logic         z, s, v, c;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  alu_status_core #(.WIDTH(W)) dut_i (
    .op_i(op), .a_i(a), .b_i(b),
    .result_o(res), .zero_o(z), .sign_o(s), .ovf_o(v), .carry_o(c)
  );

  task automatic model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       output logic [W-1:0] er, output logic ev, output logic ec);
    longint sx, sy, t;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    er = '0; ev = 1'b0; ec = 1'b0;
    case (o)
      4'b0000: er = x & y;
      4'b0001: er = x | y;
      4'b1100: er = ~(x | y);
      4'b0010: begin
        t  = sx + sy;
        er = x + y;
        ec = ({1'b0, x} + {1'b0, y}) > {1'b0, {W{1'b1}}};
        ev = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'b0110: begin
        t  = sx - sy;
        er = x - y;
        ec = (x >= y);
        ev = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'b0111: er = (sx < sy) ? 1 : 0;
      default: er = '0;
    endcase
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input string req);
    logic [W-1:0] er;
    logic ev, ec, ez, es;
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    model(o, x, y, er, ev, ec);
    ez = (er == '0);       // R6
    es = er[W-1];          // R7
    @(negedge clk);
    total++;
    if (res !== er || z !== ez || s !== es || v !== ev || c !== ec) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h got r=%h z%b s%b v%b c%b expected r=%h z%b s%b v%b c%b",
               req, o, x, y, res, z, s, v, c, er, ez, es, ev, ec);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: AND of zeros gives zero result, Z=1
    apply(4'b0000, 32'h0, 32'h0, "R6 idle");
    apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, "R1 and");
    apply(4'b0001, 32'hF000_0001, 32'h0000_1000, "R1 or");
    apply(4'b1100, 32'h0000_0000, 32'h0000_0000, "R1 nor all ones R7");
    apply(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF, "R1 nor to zero R6");
    apply(4'b0001, 32'h8000_0000, 32'h8000_0000, "R8 logic no flags");
    apply(4'b0010, 32'h0000_0005, 32'h0000_0007, "R2 add small");
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R2 add carry wrap R6");
    apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R4 add pos overflow");
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000, "R4 add neg overflow");
    apply(4'b0110, 32'h0000_0009, 32'h0000_0009, "R3 sub equal");
    apply(4'b0110, 32'h0000_0003, 32'h0000_0005, "R3 sub borrow R7");
    apply(4'b0110, 32'h8000_0000, 32'h0000_0001, "R4 sub overflow");
    apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R4 sub overflow pos");
    apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0001, "R5 slt neg lt pos");
    apply(4'b0111, 32'h0000_0001, 32'hFFFF_FFFF, "R5 slt pos ge neg");
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001, "R5 slt across overflow");
    apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, "R5 slt across overflow rev");
    apply(4'b0111, 32'h1234_5678, 32'h1234_5678, "R5 slt equal");
    for (int k = 0; k < 16; k++) begin
      if (!(k inside {0, 1, 2, 6, 7, 12}))
        apply(4'(k), 32'hDEAD_BEEF, 32'h8000_0001, "R9 undefined code");
    end
    for (int n = 0; n < 600; n++) begin
      logic [3:0] pick;
      case (n % 6)
        0: pick = 4'b0000;
        1: pick = 4'b0001;
        2: pick = 4'b0010;
        3: pick = 4'b0110;
        4: pick = 4'b0111;
        default: pick = 4'b1100;
      endcase
      apply(pick, $urandom, $urandom, "R2 R3 R4 R5 sweep");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule